// File: doc/BRIEF.md
# Elevator Car Controller

This block is a synchronous controller for one car that serves a parameterised number of floors, eight by default. Passengers inside the car select destinations on one level-sensitive switch per floor. Each new destination goes to the tail of an ordered list of distinct pending floors. The controller moves the car toward the floor at the head of that list. It also stops at any listed floor it passes, and removes each floor from the list when the car arrives there. Door handling is driven by four debounced buttons: an open and a close button inside the car, and an open and a close button at the landing.

The controller runs six states: idle, travelling up, travelling down, door open, dwell and door closing. Travel between adjacent floors, the open interval, the dwell and the closing time are each a parameterised number of clock ticks. The outputs are the current floor, the travel direction, a door-open indicator, the pending list with its length, and one seven-segment digit for each list slot.

Top module: `elevator_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the car idle at floor 0, with `dir_o` = 00, `door_open_o` = 0, `pend_count_o` = 0 and every `pend_seg_o` digit blank (7'h00). This holds whatever state the car was in when reset arrived.
- R2: A floor request is accepted only when three things are true: its input is high, the input has been low since that floor was last accepted (or since reset), and the floor is not already pending. At most one floor is accepted per clock cycle, the lowest index first. It is appended at the tail, slot 0 being the head at `pend_floors_o[FW-1:0]`. A duplicate request leaves the list unchanged.
- R3: In idle, the checks are made in this order. A held or pressed open button opens the door. Otherwise, if the current floor is pending, the door opens with no movement. Otherwise the car starts moving toward the head floor: `dir_o` = 01 for up and 10 for down. In the door states `dir_o` is 00.
- R4: While travelling, the floor steps by one every TRAVEL_TICKS cycles, and it changes at no other time. From idle with an empty list, the door opens 2 + TRAVEL_TICKS × distance clock edges after the request is sampled, counting the sampling edge as edge 1.
- R5: When the car reaches a pending floor, the controller enters the door-open state and removes that floor from the list. Every later entry moves up one slot.
- R6: With no buttons pressed, `door_open_o` stays high for OPEN_TICKS + DWELL_TICKS cycles (open, then dwell). It then stays low for CLOSE_TICKS cycles of closing before the car is idle again. The door is never open while the car travels.
- R7: Pressing or holding an open button in the open or dwell state restarts the open interval and latches a hold. Once held, the door stays open indefinitely until a close button is pressed. A close press in the open or dwell state starts closing at once.
- R8: An open button during closing returns the controller to the open state with a full open interval.
- R9: Digit k of `pend_seg_o` (bits 7k+6..7k, segment order gfedcba, active high) shows list slot k one cycle after the list changes. The patterns are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07. Slots at or beyond the list length are blank (00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| floor_req_i | input | NUM_FLOORS | In-car destination switches, one per floor, level-sensitive |
| car_open_i | input | 1 | Door open button inside the car |
| car_close_i | input | 1 | Door close button inside the car |
| hall_open_i | input | 1 | Door open button at the landing |
| hall_close_i | input | 1 | Door close button at the landing |
| cur_floor_o | output | FW | Current floor number |
| dir_o | output | 2 | 01 up, 10 down, 00 stopped |
| door_open_o | output | 1 | High while the door is open or dwelling |
| pend_floors_o | output | NUM_FLOORS×FW | Pending list, slot k at bits k×FW upward, slot 0 is the head |
| pend_count_o | output | CW | Number of valid pending entries |
| pend_seg_o | output | NUM_FLOORS×7 | Seven-segment pattern per list slot |

## Verification
Several properties are checked on every cycle. The list never overflows and never holds a duplicate floor. The floor never changes outside travel. The car only moves while work is pending. Each arrival at a pending floor opens the door and clears that floor. A held door with no buttons pressed stays open. Some behaviour can only be shown by the bench scenarios: the exact clock-edge counts of travel and door phases, the order in which simultaneous requests enter the list and shift out, the segment patterns, and the full-length reopen after a press during closing.

// File: rtl/elev_pkg.sv
package elev_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_UP    = 3'd1,
    ST_DOWN  = 3'd2,
    ST_OPEN  = 3'd3,
    ST_CLOSE = 3'd4,
    ST_WAIT  = 3'd5
  } car_state_t;

  localparam logic [1:0] DIR_STOP = 2'b00;
  localparam logic [1:0] DIR_UP   = 2'b01;
  localparam logic [1:0] DIR_DOWN = 2'b10;

  // gfedcba, active high; codes above 9 are blank
  function automatic logic [6:0] seg_of(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/elev_tick_timer.sv
module elev_tick_timer #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] len,
  output logic          expire
);

  logic [TW-1:0] cnt_q;

  // a phase of length len lasts exactly len cycles after the load
  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start)         cnt_q <= len - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/elev_req_queue.sv
module elev_req_queue #(
  parameter int NUM = 8,
  parameter int FW  = 3,
  parameter int CW  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM-1:0]   req,
  input  logic             rm_en,
  input  logic [FW-1:0]    rm_floor,
  output logic [NUM*FW-1:0] slots,
  output logic [CW-1:0]    count,
  output logic [NUM-1:0]   mask
);

  logic [FW-1:0]  q_q   [NUM];
  logic [FW-1:0]  q_n   [NUM];
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  cnt_n;
  logic [NUM-1:0] armed_q;
  logic [NUM-1:0] armed_n;
  logic           rm_hit;
  logic [CW-1:0]  rm_pos;
  logic           pick_en;
  logic [FW-1:0]  pick_floor;

  always_comb begin
    mask = '0;
    for (int i = 0; i < NUM; i++)
      if (CW'(i) < cnt_q) mask[q_q[i]] = 1'b1;
  end

  always_comb begin
    rm_hit = 1'b0;
    rm_pos = '0;
    for (int j = 0; j < NUM; j++)
      if (rm_en && CW'(j) < cnt_q && q_q[j] == rm_floor) begin
        rm_hit = 1'b1;
        rm_pos = CW'(j);
      end

    // lowest eligible floor wins
    pick_en    = 1'b0;
    pick_floor = '0;
    for (int i = NUM - 1; i >= 0; i--)
      if (req[i] && armed_q[i] && !mask[i] && !(rm_en && rm_floor == FW'(i))) begin
        pick_en    = 1'b1;
        pick_floor = FW'(i);
      end

    for (int i = 0; i < NUM; i++) q_n[i] = q_q[i];
    cnt_n = cnt_q;

    if (rm_hit) begin
      for (int i = 0; i < NUM - 1; i++)
        if (CW'(i) >= rm_pos) q_n[i] = q_q[i+1];
      q_n[NUM-1] = '0;
      cnt_n = cnt_q - 1'b1;
    end

    if (pick_en && cnt_n < CW'(NUM)) begin
      for (int i = 0; i < NUM; i++)
        if (CW'(i) == cnt_n) q_n[i] = pick_floor;
      cnt_n = cnt_n + 1'b1;
    end

    for (int i = 0; i < NUM; i++)
      if (CW'(i) >= cnt_n) q_n[i] = '0;

    for (int i = 0; i < NUM; i++)
      armed_n[i] = !req[i] ? 1'b1 :
                   (pick_en && pick_floor == FW'(i)) ? 1'b0 : armed_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= '1;
      for (int i = 0; i < NUM; i++) q_q[i] <= '0;
    end else begin
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
      for (int i = 0; i < NUM; i++) q_q[i] <= q_n[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM; g++) begin : g_slot
      assign slots[g*FW +: FW] = q_q[g];
    end
  endgenerate

  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(NUM)); // R2
  AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (rst)
    $countones(mask) == int'(cnt_q)); // R2
  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($countones(mask) <= $countones($past(mask)) + 1)); // R2
  AST_REMOVE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rm_en && mask[rm_floor]) |=> !mask[$past(rm_floor)]); // R5

endmodule

// File: rtl/elev_seg_enc.sv
module elev_seg_enc
  import elev_pkg::*;
#(
  parameter int NUM = 8,
  parameter int FW  = 3,
  parameter int CW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM*FW-1:0] slots,
  input  logic [CW-1:0]     count,
  output logic [NUM*7-1:0]  segs
);

  genvar k;
  generate
    for (k = 0; k < NUM; k++) begin : g_digit
      logic [6:0] seg_q;
      always_ff @(posedge clk) begin
        if (rst)                    seg_q <= 7'h00;
        else if (CW'(k) < count)    seg_q <= seg_of(4'(slots[k*FW +: FW]));
        else                        seg_q <= 7'h00;
      end
      assign segs[k*7 +: 7] = seg_q;
    end
  endgenerate

endmodule

// File: rtl/elevator_ctrl.sv
module elevator_ctrl
  import elev_pkg::*;
#(
  parameter int NUM_FLOORS   = 8,
  parameter int TRAVEL_TICKS = 4,
  parameter int OPEN_TICKS   = 3,
  parameter int DWELL_TICKS  = 2,
  parameter int CLOSE_TICKS  = 2,
  localparam int FW   = $clog2(NUM_FLOORS),
  localparam int CW   = $clog2(NUM_FLOORS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_FLOORS-1:0]    floor_req_i,
  input  logic                     car_open_i,
  input  logic                     car_close_i,
  input  logic                     hall_open_i,
  input  logic                     hall_close_i,
  output logic [FW-1:0]            cur_floor_o,
  output logic [1:0]               dir_o,
  output logic                     door_open_o,
  output logic [NUM_FLOORS*FW-1:0] pend_floors_o,
  output logic [CW-1:0]            pend_count_o,
  output logic [NUM_FLOORS*7-1:0]  pend_seg_o
);

  localparam int MAX_A = (TRAVEL_TICKS > OPEN_TICKS) ? TRAVEL_TICKS : OPEN_TICKS;
  localparam int MAX_B = (DWELL_TICKS > CLOSE_TICKS) ? DWELL_TICKS : CLOSE_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_T + 1);

  car_state_t      state_q, nxt;
  logic [FW-1:0]   floor_q, floor_n;
  logic            hold_q, hold_n;
  logic [1:0]      dir_q;
  logic            door_q;

  logic            open_any, close_any;
  logic [FW-1:0]   head, floor_up, floor_dn, step_floor;
  logic [NUM_FLOORS-1:0] mask;
  logic [CW-1:0]   count;
  logic            rm_en;
  logic [FW-1:0]   rm_floor;
  logic            trav_start, trav_exp;
  logic            door_start, door_restart, door_exp;
  logic [TW-1:0]   door_len;

  assign open_any   = car_open_i | hall_open_i;
  assign close_any  = car_close_i | hall_close_i;
  assign head       = pend_floors_o[FW-1:0];
  assign floor_up   = floor_q + 1'b1;
  assign floor_dn   = floor_q - 1'b1;
  assign step_floor = (state_q == ST_DOWN) ? floor_dn : floor_up;

  elev_req_queue #(.NUM(NUM_FLOORS), .FW(FW), .CW(CW)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .req      (floor_req_i),
    .rm_en    (rm_en),
    .rm_floor (rm_floor),
    .slots    (pend_floors_o),
    .count    (count),
    .mask     (mask)
  );

  elev_tick_timer #(.TW(TW)) u_travel_tmr (
    .clk    (clk),
    .rst    (rst),
    .start  (trav_start),
    .len    (TW'(TRAVEL_TICKS)),
    .expire (trav_exp)
  );

  elev_tick_timer #(.TW(TW)) u_door_tmr (
    .clk    (clk),
    .rst    (rst),
    .start  (door_start),
    .len    (door_len),
    .expire (door_exp)
  );

  elev_seg_enc #(.NUM(NUM_FLOORS), .FW(FW), .CW(CW)) u_seg (
    .clk   (clk),
    .rst   (rst),
    .slots (pend_floors_o),
    .count (count),
    .segs  (pend_seg_o)
  );

  always_comb begin
    nxt          = state_q;
    floor_n      = floor_q;
    hold_n       = hold_q;
    rm_en        = 1'b0;
    rm_floor     = floor_q;
    trav_start   = 1'b0;
    door_restart = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (open_any) begin
          nxt    = ST_OPEN;
          hold_n = 1'b1;
        end else if (mask[floor_q]) begin
          nxt   = ST_OPEN;
          rm_en = 1'b1;
        end else if (count != '0) begin
          nxt        = (head > floor_q) ? ST_UP : ST_DOWN;
          trav_start = 1'b1;
        end
      end
      ST_UP, ST_DOWN: begin
        if (trav_exp) begin
          floor_n = step_floor;
          if (mask[step_floor]) begin
            nxt      = ST_OPEN;
            rm_en    = 1'b1;
            rm_floor = step_floor;
          end else begin
            trav_start = 1'b1;
          end
        end
      end
      ST_OPEN: begin
        rm_en = mask[floor_q];
        if (open_any) begin
          hold_n       = 1'b1;
          door_restart = 1'b1;
        end else if (close_any) begin
          hold_n = 1'b0;
          nxt    = ST_CLOSE;
        end else if (!hold_q && door_exp) begin
          nxt = ST_WAIT;
        end
      end
      ST_WAIT: begin
        rm_en = mask[floor_q];
        if (open_any) begin
          hold_n = 1'b1;
          nxt    = ST_OPEN;
        end else if (close_any || door_exp) begin
          nxt = ST_CLOSE;
        end
      end
      ST_CLOSE: begin
        if (open_any)      nxt = ST_OPEN;
        else if (door_exp) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign door_start = door_restart ||
                      ((nxt != state_q) &&
                       (nxt == ST_OPEN || nxt == ST_WAIT || nxt == ST_CLOSE));

  always_comb begin
    case (nxt)
      ST_OPEN: door_len = TW'(OPEN_TICKS);
      ST_WAIT: door_len = TW'(DWELL_TICKS);
      default: door_len = TW'(CLOSE_TICKS);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      floor_q <= '0;
      hold_q  <= 1'b0;
      dir_q   <= DIR_STOP;
      door_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      floor_q <= floor_n;
      hold_q  <= hold_n;
      dir_q   <= (nxt == ST_UP) ? DIR_UP : (nxt == ST_DOWN) ? DIR_DOWN : DIR_STOP;
      door_q  <= (nxt == ST_OPEN) || (nxt == ST_WAIT);
    end
  end

  assign cur_floor_o  = floor_q;
  assign dir_o        = dir_q;
  assign door_open_o  = door_q;
  assign pend_count_o = count;

  AST_FLOOR_STILL: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_UP && state_q != ST_DOWN) |=> $stable(floor_q)); // R4
  AST_MOVE_HAS_WORK: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_UP || state_q == ST_DOWN) |-> (count != '0)); // R3
  AST_ARRIVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_UP || state_q == ST_DOWN) && trav_exp && mask[step_floor])
      |=> (state_q == ST_OPEN && !mask[floor_q])); // R5
  AST_SHUT_WHILE_MOVING: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_UP || state_q == ST_DOWN) |-> !door_open_o); // R6
  AST_HOLD_KEEPS_OPEN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN && hold_q && !open_any && !close_any) |=> (state_q == ST_OPEN)); // R7

endmodule

// File: tb/sim_elevator_ctrl.sv
module sim_elevator_ctrl;

  localparam int NF  = 8;
  localparam int FW  = 3;
  localparam int CW  = 4;
  localparam int TT  = 4;
  localparam int OT  = 3;
  localparam int DT  = 2;
  localparam int CT  = 2;
  localparam int NV  = 6;
  localparam int VEC_FLOOR [NV] = '{3, 3, 7, 0, 5, 4};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NF-1:0]   floor_req = '0;
  logic            car_open = 1'b0, car_close = 1'b0;
  logic            hall_open = 1'b0, hall_close = 1'b0;
  logic [FW-1:0]   cur_floor;
  logic [1:0]      dir;
  logic            door_open;
  logic [NF*FW-1:0] pend_floors;
  logic [CW-1:0]   pend_count;
  logic [NF*7-1:0] pend_seg;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  elevator_ctrl #(
    .NUM_FLOORS(NF), .TRAVEL_TICKS(TT), .OPEN_TICKS(OT),
    .DWELL_TICKS(DT), .CLOSE_TICKS(CT)
  ) u0 (
    .clk(clk), .rst(rst), .floor_req_i(floor_req),
    .car_open_i(car_open), .car_close_i(car_close),
    .hall_open_i(hall_open), .hall_close_i(hall_close),
    .cur_floor_o(cur_floor), .dir_o(dir), .door_open_o(door_open),
    .pend_floors_o(pend_floors), .pend_count_o(pend_count), .pend_seg_o(pend_seg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int slot(input int k);
    return int'(pend_floors[k*FW +: FW]);
  endfunction

  function automatic int seg(input int k);
    return int'(pend_seg[k*7 +: 7]);
  endfunction

  // wait at negedges until door_open equals lvl; returns edges taken
  task automatic wait_door(input logic lvl, output int n);
    n = 0;
    while (door_open != lvl && n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int prev, n, d, dir_seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 floor", int'(cur_floor), 0);
    chk("R1 dir", int'(dir), 0);
    chk("R1 door", int'(door_open), 0);
    chk("R1 count", int'(pend_count), 0);
    chk("R1 segs", (pend_seg == '0) ? 1 : 0, 1);
    rst = 1'b0;

    // vector walk: travel time, direction, arrival, door sequence
    prev = 0;
    for (int v = 0; v < NV; v++) begin
      int f;
      f = VEC_FLOOR[v];
      d = f - prev;
      @(negedge clk) floor_req[f] = 1'b1;
      @(posedge clk);
      @(negedge clk) floor_req = '0;
      n = 1; dir_seen = -1;
      while (!door_open && n < 400) begin
        @(posedge clk); n++;
        @(negedge clk);
        if (n == 2) dir_seen = int'(dir);
      end
      chk("R4 travel edges", n, 2 + TT * ((d < 0) ? -d : d));
      chk("R3 direction", dir_seen, (d > 0) ? 1 : (d < 0) ? 2 : 0);
      chk("R5 arrival floor", int'(cur_floor), f);
      chk("R5 removed", int'(pend_count), 0);
      wait_door(1'b0, n);
      chk("R6 open length", n, OT + DT);
      repeat (CT + 2) @(negedge clk);
      chk("R6 idle after close", int'(dir), 0);
      prev = f;
    end

    // R2 order of simultaneous requests, car at floor 4
    floor_req = (8'b1 << 6) | (8'b1 << 2);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R2 count two", int'(pend_count), 2);
    chk("R2 slot0", slot(0), 2);
    chk("R2 slot1", slot(1), 6);
    floor_req = '0;
    @(negedge clk) floor_req[6] = 1'b1;
    repeat (2) @(negedge clk);
    floor_req = '0;
    @(negedge clk);
    chk("R2 duplicate ignored", int'(pend_count), 2);
    chk("R9 seg slot0", seg(0), 'h5B);
    chk("R9 seg slot1", seg(1), 'h7D);
    chk("R9 seg blank", seg(2), 0);

    wait_door(1'b1, n);
    chk("R5 first stop", int'(cur_floor), 2);
    chk("R5 shift count", int'(pend_count), 1);
    chk("R5 shift slot0", slot(0), 6);
    @(negedge clk);
    chk("R9 seg after shift", seg(0), 'h7D);
    chk("R9 seg freed", seg(1), 0);
    wait_door(1'b0, n);
    wait_door(1'b1, n);
    chk("R5 second stop", int'(cur_floor), 6);

    // R7 hold, then close press
    car_open = 1'b1;
    repeat (20) @(negedge clk);
    chk("R7 held open", int'(door_open), 1);
    car_open = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 stays after release", int'(door_open), 1);
    hall_close = 1'b1;
    @(posedge clk);
    @(negedge clk) hall_close = 1'b0;
    chk("R7 close press", int'(door_open), 0);

    // R8 reopen during closing
    hall_open = 1'b1;
    @(posedge clk);
    @(negedge clk) hall_open = 1'b0;
    chk("R8 reopened", int'(door_open), 1);
    wait_door(1'b0, n);
    chk("R8 full interval", n, OT + DT);
    repeat (CT + 2) @(negedge clk);

    // R1 reset during travel
    floor_req[1] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 moving before reset", int'(dir), 2);
    floor_req = '0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset floor", int'(cur_floor), 0);
    chk("R1 reset count", int'(pend_count), 0);
    chk("R1 reset dir", int'(dir), 0);
    chk("R1 reset segs", (pend_seg == '0) ? 1 : 0, 1);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    chk("R1 stays idle", int'(cur_floor), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule